// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between a synchronous host and an external asynchronous static RAM of 1M words by 16 bits. The host makes single-word requests over a valid/acknowledge handshake. Each request carries a word address, write data, a per-byte lane mask and a read/write flag. The controller turns each request into a timed sequence on the memory pins. These pins are two chip enables of opposite polarity, an output enable, a write strobe, two byte-lane enables, and a split data bus made of a drive value, a drive enable and an input.

No pin timing is tied to the clock directly. Each phase length is derived from nanosecond figures by taking the ceiling of the figure divided by the clock period, with a minimum of one cycle. A read lasts long enough for the cycle time, the address access time and the output-enable access time. A write lasts long enough for the cycle time, the strobe width, the enable-to-end time and the data setup time. After a read, a turnaround gap keeps the controller from driving the data bus until the memory's outputs are guaranteed to have floated.

The host holds `req_valid` and its fields until it sees `req_ack`. In that cycle it either drops the request or presents the next one.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, `mem_en_n`=1, `mem_en`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_lo_n`=1, `mem_hi_n`=1, `mem_dq_oe`=0 and `req_ack`=0.
- R2: A read holds `mem_en_n`=0, `mem_en`=1, `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD_CYC consecutive cycles, which is 7 at the defaults with an 8 ns clock. During those cycles `mem_addr` equals the request address, `mem_lo_n` = !mask[0] (lane bits 7:0) and `mem_hi_n` = !mask[1] (lane bits 15:8).
- R3: Read data is sampled from `mem_dq_in` in the last read cycle and appears on `rd_data` in the cycle `req_ack` is high. A lane whose mask bit is 0 returns zero, so a mask of 00 returns 0x0000.
- R4: A write holds the enables active, `mem_we_n`=0 and `mem_dq_oe`=1 for exactly WR_CYC consecutive cycles, which is 7 at the defaults. `mem_oe_n` stays 1 throughout. `mem_dq_out` carries the request data up to and including the last strobe cycle. The lane enables follow the mask as in R2, so an unmasked lane keeps its old memory contents.
- R5: `mem_dq_oe` is 1 only while the memory is selected and `mem_we_n` is 0.
- R6: When a write follows a read, `mem_dq_oe` rises no sooner than TA_CYC cycles after `mem_oe_n` rises (4 at the defaults). It rises exactly TA_CYC cycles after when the write is presented at once. Reads and writes that follow a write are not delayed.
- R7: `req_ack` is a one-cycle pulse, given once per access in the cycle after the phase ends. Back-to-back accesses without turnaround are separated by exactly two deselected cycles.
- R8: `mem_addr` and the lane enables do not change while the memory stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit0 lower byte, bit1 upper byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid with req_ack after a read |
| mem_addr | output | 20 | Memory address pins |
| mem_en_n | output | 1 | Active-low chip enable |
| mem_en | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lo_n | output | 1 | Lower byte lane enable, active low |
| mem_hi_n | output | 1 | Upper byte lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The memory model puts valid data on the bus only after the output enable has been low for the full access window. It puts garbage on disabled lanes. A controller that samples one cycle early, or that does not zero masked lanes, returns wrong read data. A read followed at once by a write measures the turnaround gap exactly: a design that skips or shortens it drives the bus while the memory may still be driving, and a design that over-waits or also delays read-to-read or write-to-write traffic shows a wrong gap. A partial-lane write followed by a full read shows whether the other lane was left intact. An access at the top address checks that no address bit is dropped.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;

  localparam int unsigned LANES = 2;

  // Whole clock cycles covering a window of ns nanoseconds, never below one.
  function automatic int unsigned span_cycles(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq import asram_pkg::*; #(
  parameter int W = 4,
  parameter logic [W-1:0] RD_LAST = '0,
  parameter logic [W-1:0] WR_LAST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic         ph_zero,
  input  logic         ta_zero,
  output phase_t       phase_q,
  output phase_t       phase_nxt,
  output logic         start,
  output logic         rd_done,
  output logic [W-1:0] ph_val,
  output logic         ack
);
  logic wr_done;
  logic ack_q;

  always_comb begin
    phase_nxt = phase_q;
    start     = 1'b0;
    rd_done   = 1'b0;
    wr_done   = 1'b0;
    ph_val    = RD_LAST;
    unique case (phase_q)
      PH_IDLE: begin
        // A write must also wait for the bus turnaround after a read.
        if (req_valid && !ack_q && (!req_write || ta_zero)) begin
          start     = 1'b1;
          phase_nxt = req_write ? PH_WRITE : PH_READ;
          ph_val    = req_write ? WR_LAST : RD_LAST;
        end
      end
      PH_READ: if (ph_zero) begin
        rd_done   = 1'b1;
        phase_nxt = PH_IDLE;
      end
      PH_WRITE: if (ph_zero) begin
        wr_done   = 1'b1;
        phase_nxt = PH_IDLE;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      ack_q   <= rd_done | wr_done;
    end
  end

  assign ack = ack_q;

  assert_ack_in_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (phase_q == PH_IDLE));
  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
endmodule

// File: rtl/asram_lanes.sv
module asram_lanes import asram_pkg::*; #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  phase_t           phase_nxt,
  input  logic             rd_done,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_mask,
  input  logic [DW-1:0]    dq_in,
  output logic [AW-1:0]    mem_addr,
  output logic             en_n,
  output logic             en,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] lane_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic [DW-1:0]    rd_data
);
  localparam int BW = DW / LANES;

  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] mask_use;
  logic             active;

  assign mask_use = start ? req_mask : mask_q;
  assign active   = (phase_nxt != PH_IDLE);

  // Every pin is a flop loaded from the next phase, so the pins change
  // on the same edge as the sequencer state and never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      mem_addr <= '0;
      dq_out   <= '0;
      en_n     <= 1'b1;
      en       <= 1'b0;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      lane_n   <= '1;
    end else begin
      if (start) begin
        mask_q   <= req_mask;
        mem_addr <= req_addr;
        dq_out   <= req_wdata;
      end
      en_n   <= !active;
      en     <= active;
      oe_n   <= !(phase_nxt == PH_READ);
      we_n   <= !(phase_nxt == PH_WRITE);
      dq_oe  <= (phase_nxt == PH_WRITE);
      lane_n <= ~(mask_use & {LANES{active}});
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data[i*BW +: BW] <= '0;
      else if (rd_done) rd_data[i*BW +: BW] <= mask_q[i] ? dq_in[i*BW +: BW] : '0;
    end
  end

  assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && !en_n && en && oe_n));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl import asram_pkg::*; #(
  parameter int          AW     = 20,
  parameter int          DW     = 16,
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned RC_NS  = 55,
  parameter int unsigned AA_NS  = 55,
  parameter int unsigned OA_NS  = 30,
  parameter int unsigned WC_NS  = 55,
  parameter int unsigned WP_NS  = 40,
  parameter int unsigned CW_NS  = 45,
  parameter int unsigned DS_NS  = 25,
  parameter int unsigned HZ_NS  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_mask,
  output logic          req_ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en_n,
  output logic          mem_en,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lo_n,
  output logic          mem_hi_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC = umax(span_cycles(RC_NS, CLK_NS),
                                   umax(span_cycles(AA_NS, CLK_NS), span_cycles(OA_NS, CLK_NS)));
  localparam int unsigned WR_CYC = umax(umax(span_cycles(WC_NS, CLK_NS), span_cycles(WP_NS, CLK_NS)),
                                   umax(span_cycles(CW_NS, CLK_NS), span_cycles(DS_NS, CLK_NS)));
  localparam int unsigned TA_CYC = span_cycles(HZ_NS, CLK_NS);
  localparam int unsigned MAX_CYC = umax(RD_CYC, umax(WR_CYC, TA_CYC));
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] TA_LAST = CW'(TA_CYC - 1);

  phase_t          phase_q, phase_nxt;
  logic            start, rd_done, ph_zero, ta_zero;
  logic [CW-1:0]   ph_val;
  logic [LANES-1:0] lane_n;

  asram_seq #(.W(CW), .RD_LAST(RD_LAST), .WR_LAST(WR_LAST)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .ph_zero(ph_zero), .ta_zero(ta_zero), .phase_q(phase_q), .phase_nxt(phase_nxt),
    .start(start), .rd_done(rd_done), .ph_val(ph_val), .ack(req_ack));

  asram_timer #(.W(CW)) u_phase_tmr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(ph_val), .zero(ph_zero));

  asram_timer #(.W(CW)) u_turn_tmr (
    .clk(clk), .rst_n(rst_n), .load(rd_done), .load_val(TA_LAST), .zero(ta_zero));

  asram_lanes #(.AW(AW), .DW(DW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_nxt(phase_nxt), .rd_done(rd_done),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .dq_in(mem_dq_in),
    .mem_addr(mem_addr), .en_n(mem_en_n), .en(mem_en), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .lane_n(lane_n), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe), .rd_data(rd_data));

  assign mem_lo_n = lane_n[0];
  assign mem_hi_n = lane_n[1];

  // Pin-level window counters that feed the assertions below.
  logic [CW:0] rd_run, wr_run, hz_cnt;
  logic        sel;
  assign sel = !mem_en_n && mem_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run <= '0;
      wr_run <= '0;
      hz_cnt <= (CW+1)'(TA_CYC);
    end else begin
      rd_run <= !mem_oe_n ? rd_run + 1'b1 : '0;
      wr_run <= !mem_we_n ? wr_run + 1'b1 : '0;
      if (!mem_oe_n)                     hz_cnt <= '0;
      else if (hz_cnt < (CW+1)'(TA_CYC)) hz_cnt <= hz_cnt + 1'b1;
    end
  end

  assert_read_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (rd_run == (CW+1)'(RD_CYC)));
  assert_write_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wr_run == (CW+1)'(WR_CYC)));
  assert_no_read_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (hz_cnt >= (CW+1)'(TA_CYC)));
  assert_pins_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> ($stable(mem_addr) && $stable(lane_n)));
endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  localparam int RD_EXP = (55 + 7) / 8;
  localparam int WR_EXP = (55 + 7) / 8;
  localparam int TA_EXP = (25 + 7) / 8;

  typedef struct {
    bit          wr;
    logic [19:0] a;
    logic [15:0] d;
    logic [1:0]  m;
    logic [15:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ack;
  logic [15:0] rd_data, mem_dq_out;
  logic [15:0] mem_dq_in = 16'hBAD0;
  logic [19:0] mem_addr;
  logic mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_oe;

  always #4 clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .req_ack(req_ack),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_en_n(mem_en_n), .mem_en(mem_en),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int nchk = 0, nfail = 0;
  bit done = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  // Scoreboard and shadow memories
  item_t q[$];
  logic [15:0] smem [bit [19:0]];
  logic [15:0] bmem [bit [19:0]];

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction

  task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
    item_t it;
    logic [15:0] old;
    old = smem.exists(a) ? smem[a] : 16'h0000;
    it.wr = wr; it.a = a; it.d = d; it.m = m;
    it.exp = {m[1] ? old[15:8] : 8'h00, m[0] ? old[7:0] : 8'h00};
    if (wr) smem[a] = merge(old, d, m);
    q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
  endtask

  // Pin monitor and memory model, all at the falling edge
  int rd_run = 0, wr_run = 0, idle_run = 0;
  int last_idle = 0, last_ta = 0, oe_rise_cyc = 0;
  bit prev_read = 0, ack_prev = 0, sel_prev = 0, oe_prev = 1, dqoe_prev = 0;
  int bus_err = 0, stab_err = 0, ack_err = 0, oewr_err = 0;
  logic [19:0] addr_prev = '0;
  logic [1:0]  lanes_prev = '0;
  logic [15:0] pend_d = '0;
  logic [1:0]  pend_m = '0;
  logic [19:0] pend_a = '0;

  always @(negedge clk) begin
    bit sel;
    item_t it;
    logic [15:0] cur;
    sel = !mem_en_n && mem_en;
    if (rst_n) begin
      // R2 read phase
      if (sel && !mem_oe_n) begin
        rd_run++;
        if (rd_run == 1 && q.size() > 0) begin
          chk(mem_addr == q[0].a, "R2 read address", 32'(mem_addr), 32'(q[0].a));
          chk({mem_hi_n, mem_lo_n} == ~q[0].m, "R2 read lanes", 32'({mem_hi_n, mem_lo_n}), 32'(~q[0].m));
        end
      end else if (rd_run != 0) begin
        chk(rd_run == RD_EXP, "R2 read strobe length", 32'(rd_run), 32'(RD_EXP));
        rd_run = 0; prev_read = 1;
      end
      if (oe_prev == 0 && mem_oe_n) oe_rise_cyc = cyc;
      // R4 write phase
      if (sel && !mem_we_n) begin
        wr_run++;
        if (!mem_oe_n) oewr_err++;
        pend_d = mem_dq_out; pend_m = ~{mem_hi_n, mem_lo_n}; pend_a = mem_addr;
        if (wr_run == 1 && q.size() > 0)
          chk(mem_addr == q[0].a, "R4 write address", 32'(mem_addr), 32'(q[0].a));
      end else if (wr_run != 0) begin
        chk(wr_run == WR_EXP, "R4 write strobe length", 32'(wr_run), 32'(WR_EXP));
        if (q.size() > 0) begin
          chk(pend_d == q[0].d, "R4 write data at strobe end", 32'(pend_d), 32'(q[0].d));
          chk(pend_m == q[0].m, "R4 write lanes", 32'(pend_m), 32'(q[0].m));
        end
        cur = bmem.exists(pend_a) ? bmem[pend_a] : 16'h0000;
        bmem[pend_a] = merge(cur, pend_d, pend_m);
        wr_run = 0; prev_read = 0;
      end
      // R6 turnaround
      if (mem_dq_oe && !dqoe_prev && prev_read) begin
        last_ta = cyc - oe_rise_cyc;
        chk(last_ta >= TA_EXP, "R6 turnaround minimum", 32'(last_ta), 32'(TA_EXP));
      end
      // R7 idle gap
      if (!sel) idle_run++;
      else if (idle_run != 0) begin last_idle = idle_run; idle_run = 0; end
      // R5 and R8
      if (mem_dq_oe && (mem_we_n || !sel)) bus_err++;
      if (sel && sel_prev && (mem_addr != addr_prev || {mem_hi_n, mem_lo_n} != lanes_prev)) stab_err++;
      // R7 ack and R3 data
      if (req_ack) begin
        if (ack_prev) ack_err++;
        if (q.size() == 0) ack_err++;
        else begin
          it = q.pop_front();
          if (!it.wr) chk(rd_data == it.exp, "R3 read data", 32'(rd_data), 32'(it.exp));
        end
      end
    end
    // memory response: valid only after the full access window
    if (sel && !mem_oe_n && mem_we_n && rd_run >= RD_EXP) begin
      cur = bmem.exists(mem_addr) ? bmem[mem_addr] : 16'h0000;
      mem_dq_in = {mem_hi_n ? 8'h5A : cur[15:8], mem_lo_n ? 8'hA5 : cur[7:0]};
    end else begin
      mem_dq_in = 16'hBAD0 ^ 16'(rd_run);
    end
    ack_prev = req_ack; sel_prev = sel; oe_prev = mem_oe_n; dqoe_prev = mem_dq_oe;
    addr_prev = mem_addr; lanes_prev = {mem_hi_n, mem_lo_n};
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_oe, req_ack} == 8'b1011_1100,
        "R1 pins in reset", 32'({mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_oe, req_ack}), 32'hBC);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_oe, req_ack} == 8'b1011_1100,
        "R1 pins idle after reset", 32'({mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n, mem_dq_oe, req_ack}), 32'hBC);

    access(1, 20'h12345, 16'hBEEF, 2'b11);
    access(1, 20'h00001, 16'hAAAA, 2'b11);
    chk(last_idle == 2, "R7 write-to-write gap", 32'(last_idle), 32'd2);
    access(0, 20'h12345, 16'h0000, 2'b11);
    access(0, 20'h00001, 16'h0000, 2'b11);
    chk(last_idle == 2, "R6 read-to-read not delayed", 32'(last_idle), 32'd2);
    access(1, 20'h00001, 16'h5511, 2'b01);
    chk(last_ta == TA_EXP, "R6 exact turnaround", 32'(last_ta), 32'(TA_EXP));
    access(0, 20'h00001, 16'h0000, 2'b11);
    access(0, 20'h12345, 16'h0000, 2'b10);
    access(0, 20'h12345, 16'h0000, 2'b01);
    access(0, 20'h12345, 16'h0000, 2'b00);
    access(1, 20'hFFFFF, 16'hC3A5, 2'b11);
    access(0, 20'hFFFFF, 16'h0000, 2'b11);
    access(0, 20'h00000, 16'h0000, 2'b11);
    for (int i = 0; i < 12; i++)
      access((i % 3) != 2, 20'h00400 + 20'(i % 4), 16'(i * 16'h1357 + 16'h0101), 2'((i % 3) + 1));
    for (int i = 0; i < 4; i++)
      access(0, 20'h00400 + 20'(i), 16'h0000, 2'b11);

    repeat (4) @(negedge clk);
    chk(bus_err == 0, "R5 drive outside write", 32'(bus_err), 32'd0);
    chk(oewr_err == 0, "R4 output enable during write", 32'(oewr_err), 32'd0);
    chk(stab_err == 0, "R8 pins moved while selected", 32'(stab_err), 32'd0);
    chk(ack_err == 0, "R7 ack pulse errors", 32'(ack_err), 32'd0);
    chk(q.size() == 0, "R7 every access acknowledged", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule